// File: doc/BRIEF.md
# Bus Fence Handshake Controller

This block raises and drops the fence that isolates a power domain's bus ports from the interconnect. The caller gives a command with a direction (raise or drop) and a mask that selects which fence lines belong to the domain. The block updates its fence-request vector: it sets or clears only the selected lines and keeps every other line as it was. It then waits on the fence-acknowledge vector that comes back from the interconnect.

A raise completes when every selected acknowledge line reads 1. A drop completes when every selected acknowledge line reads 0. When the wait runs longer than a programmable number of cycles, the block ends the command and flags an error. The completion pulse and the error flag tell the power sequencer beside it when it may go on.

The fence is raised before a domain begins to power down and dropped once power-up has finished. A domain whose mask is zero has no fence lines, so its command completes at once and no handshake takes place. A mask may select lines that are not next to each other.

Top module: `busfence_ctrl`

## Requirements
- R1: After reset, `fence_req` is all zeros and `busy`, `done` and `err` are all low.
- R2: A raise command (`cmd_raise`=1) that is accepted sets every line of `fence_req` selected by `cmd_mask`. The new value is visible in the cycle after acceptance, and lines outside the mask keep their values.
- R3: A drop command (`cmd_raise`=0) that is accepted clears only the selected lines of `fence_req`. The new value is visible in the cycle after acceptance, and lines outside the mask keep their values.
- R4: A raise waits until `fence_ack` & mask equals mask. `done` goes high, with `err` low, in the cycle after the first clock edge at which the condition is sampled true.
- R5: A drop waits until `fence_ack` & mask equals zero. Acknowledge lines outside the mask have no effect on when the drop completes.
- R6: If the completion condition has not been sampled true at any of the first TIMEOUT_CYCLES clock edges after acceptance, `done` and `err` go high together in the cycle after that last edge. A partial acknowledge counts as not complete.
- R7: A command with a zero mask raises `done` in the next cycle, with `err` low. `busy` stays low and `fence_req` does not change.
- R8: Commands are accepted only while `busy` is low. A command presented while busy changes neither `fence_req` nor the number of `done` pulses.
- R9: `done` is high for exactly one cycle per accepted command, and `err` is high only together with `done`.
- R10: `busy` is high from the cycle after a non-zero-mask command is accepted up to the `done` cycle. It is low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_raise | input | 1 | 1 raises the fence, 0 drops it |
| cmd_mask | input | WIDTH | Fence lines that belong to the domain |
| fence_ack | input | WIDTH | Per-line fence status from the interconnect |
| fence_req | output | WIDTH | Per-line fence request to the interconnect |
| busy | output | 1 | Waiting on an acknowledge |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |

## Verification
Call the acceptance edge E0. The fence request vector and `busy` are due in the cycle right after E0. If the bench applies an acknowledge at the k-th falling edge after E0, `done` is due at the falling edge k+1. If the acknowledge never comes in time, `done` is due at falling edge TIMEOUT_CYCLES, with `err` set. A zero-mask command has its `done` due at falling edge 0. The bench drives inputs and samples outputs only on falling edges and counts those edges from E0. It sweeps the acknowledge delay from 0 to beyond the timeout for several masks, including masks with gaps. For each delay it checks that `done` appears at exactly the falling edge computed from the formula above.

// File: rtl/busfence_pkg.sv
package busfence_pkg;
    typedef enum logic [0:0] {
        FENCE_IDLE = 1'b0,
        FENCE_WAIT = 1'b1
    } fence_state_e;
endpackage

// File: rtl/busfence_match.sv
// Per-line completion test: a line is satisfied when unselected or when its
// acknowledge equals the requested fence level.
module busfence_match #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] ack,
    input  logic             want_high,
    output logic             met
);
    logic [WIDTH-1:0] line_ok;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign line_ok[i] = !mask[i] || (ack[i] == want_high);
    end

    assign met = &line_ok;
endmodule

// File: rtl/busfence_timer.sv
// Counts edges spent waiting; flags the last permitted edge.
module busfence_timer #(
    parameter int LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/busfence_ctrl.sv
module busfence_ctrl #(
    parameter int WIDTH          = 32,
    parameter int TIMEOUT_CYCLES = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_raise,
    input  logic [WIDTH-1:0] cmd_mask,
    input  logic [WIDTH-1:0] fence_ack,
    output logic [WIDTH-1:0] fence_req,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import busfence_pkg::*;

    typedef struct packed {
        fence_state_e     state;
        logic [WIDTH-1:0] req;
        logic [WIDTH-1:0] mask;
        logic             raise;
        logic             done;
        logic             err;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  cond_met;
    logic  time_up;

    busfence_match #(.WIDTH(WIDTH)) u_match (
        .mask      (ctl_q.mask),
        .ack       (fence_ack),
        .want_high (ctl_q.raise),
        .met       (cond_met)
    );

    busfence_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctl_q.state == FENCE_WAIT),
        .expired (time_up)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        unique case (ctl_q.state)
            FENCE_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_mask == '0) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.state = FENCE_WAIT;
                        ctl_d.mask  = cmd_mask;
                        ctl_d.raise = cmd_raise;
                        ctl_d.req   = cmd_raise ? (ctl_q.req | cmd_mask)
                                                : (ctl_q.req & ~cmd_mask);
                    end
                end
            end
            FENCE_WAIT: begin
                if (cond_met) begin
                    ctl_d.state = FENCE_IDLE;
                    ctl_d.done  = 1'b1;
                end else if (time_up) begin
                    ctl_d.state = FENCE_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.err   = 1'b1;
                end
            end
            default: ctl_d.state = FENCE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: FENCE_IDLE, req: '0, mask: '0,
                       raise: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fence_req = ctl_q.req;
    assign busy      = (ctl_q.state == FENCE_WAIT);
    assign done      = ctl_q.done;
    assign err       = ctl_q.err;
endmodule

// File: rtl/busfence_ctrl_checker.sv
module busfence_ctrl_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_raise,
    input logic [WIDTH-1:0] cmd_mask,
    input logic [WIDTH-1:0] fence_req,
    input logic             busy,
    input logic             done,
    input logic             err
);
    assert_raise_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_raise) |=> ((fence_req & $past(cmd_mask)) == $past(cmd_mask)));

    assert_drop_applied_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !cmd_raise) |=> ((fence_req & $past(cmd_mask)) == '0));

    assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_mask == '0) |=> (done && !err && !busy && $stable(fence_req)));

    assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fence_req));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_valid) |=> !done);

    assert_err_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_idle_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind busfence_ctrl busfence_ctrl_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_raise (cmd_raise),
    .cmd_mask  (cmd_mask),
    .fence_req (fence_req),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/busfence_ctrl_test.sv
module busfence_ctrl_test;
    localparam int W  = 8;
    localparam int TO = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_raise = 1'b0;
    logic [W-1:0] cmd_mask = '0;
    logic [W-1:0] fence_ack = '0;
    logic [W-1:0] fence_req;
    logic         busy, done, err;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] req_model = '0;

    always #4 clk = ~clk;

    busfence_ctrl #(.WIDTH(W), .TIMEOUT_CYCLES(TO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_raise(cmd_raise),
        .cmd_mask(cmd_mask), .fence_ack(fence_ack), .fence_req(fence_req),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One command; acknowledge value ack_val is applied at falling edge n after E0.
    // stray=1 presents a second command while busy.
    task automatic run_cmd(input bit raise, input logic [W-1:0] mask, input int n,
                           input logic [W-1:0] ack_val, input bit stray);
        bit met;
        int exp_k, got_k, pulses;
        bit got_err;
        logic [W-1:0] exp_req;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_raise = raise; cmd_mask = mask;
        exp_req = raise ? (req_model | mask) : (req_model & ~mask);
        @(negedge clk);  // falling edge 0 after E0
        cmd_valid = 1'b0;
        check(fence_req == exp_req, raise ? "R2" : "R3", fence_req, exp_req);
        check(busy == 1'b1, "R10", busy, 1);
        req_model = exp_req;
        met = raise ? ((ack_val & mask) == mask) : ((ack_val & mask) == '0);
        exp_k = (met && n < TO) ? n + 1 : TO;
        if (n == 0) fence_ack = ack_val;
        got_k = -1; got_err = 1'b0; pulses = 0;
        for (int k = 1; k <= TO + 3; k++) begin
            @(negedge clk);
            if (done) begin
                pulses++;
                if (got_k < 0) begin got_k = k; got_err = err; end
            end
            if (got_k < 0 && !done) check(busy == 1'b1, "R10", busy, 1);
            if (k == n) fence_ack = ack_val;
            if (stray && k == 2) begin
                cmd_valid = 1'b1; cmd_raise = ~raise; cmd_mask = ~mask;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        check(got_k == exp_k, met && n < TO ? (raise ? "R4" : "R5") : "R6", got_k, exp_k);
        check(got_err == !(met && n < TO), "R6", got_err, !(met && n < TO));
        check(pulses == 1, "R9", pulses, 1);
        check(fence_req == req_model, "R8", fence_req, req_model);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] masks [4];
        masks[0] = 8'h24; masks[1] = 8'h09; masks[2] = 8'h80; masks[3] = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fence_req == '0, "R1", fence_req, 0);
        check(!busy && !done && !err, "R1", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: zero mask completes at once
        cmd_valid = 1'b1; cmd_raise = 1'b1; cmd_mask = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(done && !err && !busy, "R7", {done, err, busy}, 3'b100);
        check(fence_req == '0, "R7", fence_req, 0);
        @(negedge clk);
        check(!done, "R9", done, 0);

        // Sweep delays for raise and drop over several masks
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n <= TO + 1; n++) begin
                fence_ack = fence_ack & ~masks[m];
                run_cmd(1'b1, masks[m], n, fence_ack | masks[m], 1'b0);
                fence_ack = fence_ack | masks[m];
                // R5: unmasked acknowledge lines left high must not block a drop
                run_cmd(1'b0, masks[m], n, (fence_ack & ~masks[m]) | ~masks[m], 1'b0);
            end
        end

        // R6: partial acknowledge on a raise times out
        fence_ack = '0;
        run_cmd(1'b1, 8'h24, 0, 8'h20, 1'b0);
        // R6: acknowledge only outside the mask times out
        fence_ack = '0;
        run_cmd(1'b1, 8'h09, 1, 8'hF6, 1'b0);
        // R8: command while busy ignored
        fence_ack = '0;
        run_cmd(1'b1, 8'h41, 5, 8'h41, 1'b1);
        run_cmd(1'b0, 8'h41, 4, 8'h00, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule